// File: doc/BRIEF.md
# Bit-Field Insert Unit

This block places the low bits of an insert word into a base word. The field starts at a given bit position and spans a given length, and every base bit outside the field passes through unchanged. A width-select input picks 32-bit or 64-bit operation per transaction. Position and length are 32-bit operands.

The two widths differ in how they treat position and length values that are out of range. In narrow mode only the bottom byte of each operand is used. In wide mode the full 32-bit values are compared against the width.

Operands arrive with a valid/ready handshake. The result is held in one output register with its own valid/ready pair. The unit takes one operation per cycle for as long as the consumer keeps ready high, and each result appears one cycle after its operation is accepted.

Top module: `bit_insert_unit`

## Requirements
- R1: After reset, `res_valid_o` is low, `res_o` is zero and `op_ready_o` is high.
- R2: With `wide_i`=1 (64-bit mode), position p < 64 and length l with 0 < l < 64, the field mask is ((2^l)-1) shifted left by p, truncated to 64 bits. The result is (base AND NOT mask) OR (mask AND (insert shifted left by p)).
- R3: With `wide_i`=0 (32-bit mode), only bits 31:0 of the insert and base words are used. Bits 63:32 of the result are zero, and bits 31:0 follow the R2 rule with a width of 32.
- R4: In 32-bit mode only bits 7:0 of position and of length are used. For example, a position of 0x104 acts as 4 and a length of 0x108 acts as 8.
- R5: In 64-bit mode all 32 bits of position and length are significant. A position of 0x100 counts as out of range, and a length of 0x140 counts as full.
- R6: When the effective position is at least the operand width, the result equals the base word. In 32-bit mode the upper half is still zero.
- R7: When the effective length is at least the operand width and the position is in range, the mask is an all-ones word shifted left by the position.
- R8: An effective length of zero leaves the base word unchanged.
- R9: An operation accepted on a clock edge (`op_valid_i` and `op_ready_o` both high) shows its result, with `res_valid_o` high, after that edge. While `res_ready_i` stays high, one operation is accepted on every cycle.
- R10: While `res_valid_o` is high and `res_ready_i` is low, `res_o` and `res_valid_o` hold and `op_ready_o` is low, so no new operation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Operation can be taken |
| wide_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ins_i | input | 64 | Word whose low bits form the field |
| base_i | input | 64 | Word that receives the field |
| pos_i | input | 32 | Bit position of the field's lowest bit |
| len_i | input | 32 | Field length in bits |
| res_valid_o | output | 1 | Result register holds a result |
| res_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 64 | Result word |

## Verification
On every cycle the assertions check the handshake: a result appears after each accepted operation and holds during a stall. They also check the fixed outcomes that depend on the operands alone. These are an out-of-range position returning the base word, a zero length returning the base word, and zero upper bits in 32-bit mode. The general insert arithmetic, the full-length mask, and the 8-bit reduction of narrow operands against the full 64-bit comparison can only be shown by the bench. It compares directed corner values and a seeded random stream against its own bit-by-bit model.

// File: rtl/bfi_pkg.sv
package bfi_pkg;
  parameter int unsigned DATA_W    = 64;
  parameter int unsigned NARROW_W  = 32;
  parameter int unsigned ARG_W     = 32;
  parameter int unsigned CLIP_BITS = 8;
  localparam int unsigned HI_W     = DATA_W - NARROW_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ARG_W-1:0]  arg_t;
endpackage

// File: rtl/bfi_lane.sv
module bfi_lane #(
  parameter int unsigned W         = 64,
  parameter int unsigned ARG_W     = 32,
  parameter int unsigned CLIP_BITS = 0   // 0: use full argument
) (
  input  logic [W-1:0]     ins_i,
  input  logic [W-1:0]     base_i,
  input  logic [ARG_W-1:0] pos_i,
  input  logic [ARG_W-1:0] len_i,
  output logic [W-1:0]     res_o
);
  localparam int unsigned SH_W = $clog2(W);

  logic [ARG_W-1:0] pos_e, len_e;
  logic             pos_oor, len_full;
  logic [W-1:0]     low_ones, mask, shifted;

  if (CLIP_BITS > 0 && CLIP_BITS < ARG_W) begin : g_clip
    assign pos_e = {{(ARG_W-CLIP_BITS){1'b0}}, pos_i[CLIP_BITS-1:0]};
    assign len_e = {{(ARG_W-CLIP_BITS){1'b0}}, len_i[CLIP_BITS-1:0]};
  end else begin : g_full
    assign pos_e = pos_i;
    assign len_e = len_i;
  end

  assign pos_oor  = pos_e >= ARG_W'(W);
  assign len_full = len_e >= ARG_W'(W);

  always_comb begin
    low_ones = len_full ? {W{1'b1}} : ~({W{1'b1}} << len_e[SH_W-1:0]);
    mask     = low_ones << pos_e[SH_W-1:0];
    shifted  = ins_i << pos_e[SH_W-1:0];
    res_o    = pos_oor ? base_i : ((base_i & ~mask) | (mask & shifted));
  end
endmodule

// File: rtl/bfi_out_reg.sv
module bfi_out_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  logic         vld_q;
  logic [W-1:0] q_q;

  assign in_ready_o  = ~vld_q | out_ready_i;
  assign out_valid_o = vld_q;
  assign q_o         = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      q_q   <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) q_q <= d_i;
    end
  end
endmodule

// File: rtl/bit_insert_unit.sv
module bit_insert_unit
  import bfi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] ins_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [ARG_W-1:0]  pos_i,
  input  logic [ARG_W-1:0]  len_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_o
);
  logic [NARROW_W-1:0] narrow_res;
  logic [DATA_W-1:0]   wide_res, next_res;

  bfi_lane #(.W(NARROW_W), .ARG_W(ARG_W), .CLIP_BITS(CLIP_BITS)) u_narrow (
    .ins_i (ins_i[NARROW_W-1:0]),
    .base_i(base_i[NARROW_W-1:0]),
    .pos_i (pos_i),
    .len_i (len_i),
    .res_o (narrow_res)
  );

  bfi_lane #(.W(DATA_W), .ARG_W(ARG_W), .CLIP_BITS(0)) u_wide (
    .ins_i (ins_i),
    .base_i(base_i),
    .pos_i (pos_i),
    .len_i (len_i),
    .res_o (wide_res)
  );

  assign next_res = wide_i ? wide_res : {{HI_W{1'b0}}, narrow_res};

  bfi_out_reg #(.W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (op_valid_i),
    .in_ready_o (op_ready_o),
    .d_i        (next_res),
    .out_valid_o(res_valid_o),
    .out_ready_i(res_ready_i),
    .q_o        (res_o)
  );
endmodule

// File: rtl/bit_insert_unit_chk.sv
module bit_insert_unit_chk
  import bfi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              op_ready_o,
  input logic              wide_i,
  input logic [DATA_W-1:0] ins_i,
  input logic [DATA_W-1:0] base_i,
  input logic [ARG_W-1:0]  pos_i,
  input logic [ARG_W-1:0]  len_i,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [DATA_W-1:0] res_o
);
  logic take;
  assign take = op_valid_i && op_ready_o;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> res_valid_o); // R9

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_o))); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |-> !op_ready_o); // R10

  AST_NARROW_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !wide_i) |=> (res_o[DATA_W-1:NARROW_W] == '0)); // R3

  AST_WIDE_POS_OOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && wide_i && pos_i >= ARG_W'(DATA_W)) |=> (res_o == $past(base_i))); // R6

  AST_NARROW_POS_OOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !wide_i && pos_i[CLIP_BITS-1:0] >= CLIP_BITS'(NARROW_W))
    |=> (res_o == {{HI_W{1'b0}}, $past(base_i[NARROW_W-1:0])})); // R6

  AST_WIDE_LEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && wide_i && len_i == '0) |=> (res_o == $past(base_i))); // R8
endmodule

bind bit_insert_unit bit_insert_unit_chk u_chk (.*);

// File: tb/bit_insert_unit_test.sv
`timescale 1ns/1ps
module bit_insert_unit_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        op_valid_i = 1'b0, op_ready_o, wide_i = 1'b0;
  logic [63:0] ins_i = '0, base_i = '0, res_o;
  logic [31:0] pos_i = '0, len_i = '0;
  logic        res_valid_o, res_ready_i = 1'b1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bit_insert_unit uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_bfi(logic [63:0] ins, logic [63:0] base,
                                          logic [31:0] pos, logic [31:0] len, logic wide);
    longint w  = wide ? 64 : 32;
    longint p  = wide ? longint'(pos) : longint'(pos[7:0]);
    longint l  = wide ? longint'(len) : longint'(len[7:0]);
    logic [63:0] r = wide ? base : {32'b0, base[31:0]};
    if (p >= w) return r;
    for (int i = 0; i < 64; i++)
      if (i < w && i >= p && (l >= w || (i - p) < l)) r[i] = ins[i - int'(p)];
    return r;
  endfunction

  task automatic drive(input logic [63:0] ins, input logic [63:0] base,
                       input logic [31:0] pos, input logic [31:0] len, input logic wide);
    ins_i = ins; base_i = base; pos_i = pos; len_i = len; wide_i = wide; op_valid_i = 1'b1;
  endtask

  task automatic one_op(input logic [63:0] ins, input logic [63:0] base,
                        input logic [31:0] pos, input logic [31:0] len, input logic wide,
                        input string tag);
    logic [63:0] e;
    @(negedge clk_i);
    drive(ins, base, pos, len, wide);
    e = ref_bfi(ins, base, pos, len, wide);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(res_valid_o, {tag, " valid"}, 64'(res_valid_o), 64'd1);
    chk(res_o === e, tag, res_o, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [63:0] e0, e1, prev_e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(res_valid_o == 1'b0, "R1 valid", 64'(res_valid_o), 64'd0);
    chk(res_o == '0, "R1 result", res_o, 64'd0);
    chk(op_ready_o == 1'b1, "R1 ready", 64'(op_ready_o), 64'd1);

    one_op(64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF, 32'd8, 32'd8, 1'b1, "R2 byte");
    one_op(64'h1234_5678_9ABC_DEF0, 64'h0, 32'd60, 32'd8, 1'b1, "R2 top clip");
    one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_A5A5_A5A5, 32'd0, 32'd63, 1'b1, "R2 len63");
    one_op(64'hDEAD_BEEF_0000_000F, 64'hCAFE_0000_0000_0000, 32'd4, 32'd4, 1'b0, "R3 narrow");
    one_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd28, 32'd8, 1'b0, "R3 upper zero");
    one_op(64'h0000_0000_0000_00FF, 64'h0, 32'h104, 32'h108, 1'b0, "R4 clip");
    one_op(64'h3, 64'h0, 32'hFFFF_FF01, 32'hFFFF_FF02, 1'b0, "R4 clip high");
    one_op(64'hFF, 64'h1111_2222_3333_4444, 32'h100, 32'd8, 1'b1, "R5 pos full");
    one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'd4, 32'h140, 1'b1, "R5 len full");
    one_op(64'hFF, 64'h5555_6666_7777_8888, 32'd64, 32'd4, 1'b1, "R6 wide");
    one_op(64'hFF, 64'h5555_6666_7777_8888, 32'd32, 32'd4, 1'b0, "R6 narrow");
    one_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd16, 32'd64, 1'b1, "R7 wide");
    one_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd20, 32'd200, 1'b0, "R7 narrow");
    one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 32'd5, 32'd0, 1'b1, "R8 wide");
    one_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 32'd5, 32'h100, 1'b0, "R8 narrow");

    // R9 back-to-back random stream with ready held high
    prev_e = '0;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [31:0] p, l;
      logic        w;
      @(negedge clk_i);
      if (i > 0) begin
        chk(res_valid_o && op_ready_o, "R9 stream valid", 64'(res_valid_o), 64'd1);
        chk(res_o === prev_e, "R9 stream", res_o, prev_e);
      end
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; w = 1'($urandom % 2);
      case ($urandom % 4)
        0: p = $urandom % 32;
        1: p = $urandom % 80;
        2: p = $urandom;
        default: p = 32'h100 + ($urandom % 40);
      endcase
      case ($urandom % 4)
        0: l = $urandom % 16;
        1: l = $urandom % 80;
        2: l = $urandom;
        default: l = 32'h100 + ($urandom % 40);
      endcase
      drive(a, b, p, l, w);
      prev_e = ref_bfi(a, b, p, l, w);
    end
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(res_o === prev_e, "R9 stream last", res_o, prev_e);

    // R10 stall
    @(negedge clk_i);
    res_ready_i = 1'b0;
    drive(64'hF, 64'h0, 32'd12, 32'd4, 1'b1);
    e0 = ref_bfi(64'hF, 64'h0, 32'd12, 32'd4, 1'b1);
    @(negedge clk_i);
    drive(64'hFF, 64'h0, 32'd40, 32'd8, 1'b1);
    e1 = ref_bfi(64'hFF, 64'h0, 32'd40, 32'd8, 1'b1);
    chk(op_ready_o == 1'b0, "R10 ready low", 64'(op_ready_o), 64'd0);
    repeat (3) @(negedge clk_i);
    chk(res_valid_o == 1'b1, "R10 valid held", 64'(res_valid_o), 64'd1);
    chk(res_o === e0, "R10 result held", res_o, e0);
    res_ready_i = 1'b1;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(res_o === e1, "R10 after release", res_o, e1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule